// File: doc/BRIEF.md
# Four-State Snooping Cache Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared snooping bus. Every bus transaction is atomic. A small direct-mapped array holds, for each line, a tag, a data word and a state. The state is one of invalid, shared, exclusive-clean or modified. Processor loads and stores arrive on a valid/ready handshake. A hit completes in the cycle it is presented. A miss, or a store to a line that other caches may also hold, becomes one or two bus transactions: a write-back of a dirty victim, then a read, read-for-ownership or data-less upgrade.

On the snoop side, the controller watches the transactions of other caches and answers them in the cycle they appear:

- It raises its contribution to the wired-OR shared line when it holds a valid copy of an address being read.
- When its copy is dirty, it drives the line's data out as a flush.
- It demotes or invalidates its own copy as the protocol requires.

A read that no other cache reports as shared installs the line exclusive-clean. A later store to that line then needs no bus traffic.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, so no bus request is pending and a snooped read of any address leaves the shared output low.
- R2: A processor read that hits a line in shared, exclusive-clean or modified state raises cpu_ready in the same cycle as cpu_valid, with the line's data on cpu_rdata, and issues no bus request.
- R3: A read miss issues a bus read (op code 1). The line is filled from bus_rsp_data. It becomes exclusive-clean if bus_rsp_shared is low during the grant cycle, and shared if it is high.
- R4: A write miss issues a read-for-ownership (op code 2). The line ends up modified, holding the written data.
- R5: A write to a shared line issues only an upgrade (op code 3, no data). The line then becomes modified.
- R6: A write to an exclusive-clean line makes it modified with no bus transaction.
- R7: A snooped read (op 1) of a held address raises snp_shared. An exclusive-clean or modified copy is demoted to shared. A modified copy also raises snp_flush, with its data on snp_flush_data.
- R8: A snooped read-for-ownership (op 2) or upgrade (op 3) of a held address invalidates the local copy. A modified copy is flushed, but only on read-for-ownership.
- R9: A miss whose victim line is modified first issues a write-back (op code 4), carrying the victim's address and data. A clean victim is replaced without a write-back.
- R10: If a snoop invalidates the line while an upgrade waits for the bus, the upgrade is withdrawn. The store is then served by a read-for-ownership.
- R11: A processor request whose line index matches a snoop in the same cycle is stalled (cpu_ready low) for that cycle.
- R12: While a bus transaction is outstanding, cpu_ready stays low. The requester holds cpu_valid and its request steady until cpu_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 3 | 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Requested transaction performed this cycle |
| bus_rsp_data | input | DATA_W | Fill data during grant |
| bus_rsp_shared | input | 1 | Wired-OR shared line during grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 3 | Snooped op code, same encoding as bus_req_op |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy of a snooped read |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_flush_data | output | DATA_W | Flushed data |

## Verification
The bench targets the cases where a controller most easily takes a wrong turn:

- **Fill state from the shared line.** It fills once with the shared line high and once with it low. It then tells exclusive-clean from shared by whether a later store produces an upgrade. A design that ignored the line would either upgrade silently on a shared copy or waste an upgrade on a private one.
- **Victim handling.** It evicts a dirty victim, checking the write-back's address and data, and it also evicts a clean victim. A wrong design would either lose the dirty data or emit a spurious write-back.
- **Snoop races.** It lands a snoop invalidation between the decision to upgrade and the grant. A design that kept the upgrade would end up modified on a stale copy. It also collides a snoop with a processor hit on the same line in one cycle, which would otherwise corrupt the line state.
- **Snoop responses by state.** For each snooped op it checks the shared and flush responses against the line state the bench has set up.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_RD   = 3'd1,
        BUS_RDX  = 3'd2,
        BUS_UPGR = 3'd3,
        BUS_WB   = 3'd4
    } bus_op_t;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_WB   = 2'd1,
        F_FILL = 2'd2,
        F_UPG  = 2'd3
    } req_fsm_t;

    function automatic logic st_valid(line_st_t s);
        return s != ST_I;
    endfunction

    function automatic logic st_owned(line_st_t s);
        return (s == ST_E) || (s == ST_M);
    endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    // processor-side port: read plus full-entry write
    input  logic [IDX_W-1:0]  p_idx,
    output logic [TAG_W-1:0]  p_tag,
    output line_st_t          p_st,
    output logic [DATA_W-1:0] p_data,
    input  logic              p_we,
    input  logic [TAG_W-1:0]  p_wtag,
    input  line_st_t          p_wst,
    input  logic [DATA_W-1:0] p_wdata,
    // snoop-side port: read plus state-only write
    input  logic [IDX_W-1:0]  s_idx,
    output logic [TAG_W-1:0]  s_tag,
    output line_st_t          s_st,
    output logic [DATA_W-1:0] s_data,
    input  logic              s_we,
    input  line_st_t          s_wst
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_q  [LINES];
    line_st_t          st_q   [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign p_tag  = tag_q[p_idx];
    assign p_st   = st_q[p_idx];
    assign p_data = data_q[p_idx];
    assign s_tag  = tag_q[s_idx];
    assign s_st   = st_q[s_idx];
    assign s_data = data_q[s_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]  <= '0;
                st_q[i]   <= ST_I;
                data_q[i] <= '0;
            end
        end else begin
            if (p_we) begin
                tag_q[p_idx]  <= p_wtag;
                st_q[p_idx]   <= p_wst;
                data_q[p_idx] <= p_wdata;
            end
            // snoop port has priority on the state field
            if (s_we) st_q[s_idx] <= s_wst;
        end
    end

    // R8: an invalidating snoop leaves the line invalid on the next cycle
    a_r8_snoop_inval_lands: assert property (@(posedge clk) disable iff (rst)
        (s_we && s_wst == ST_I) |=> (st_q[$past(s_idx)] == ST_I));

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import coh_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [2:0]        snp_op,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [TAG_W-1:0]  s_tag,
    input  line_st_t          s_st,
    input  logic [DATA_W-1:0] s_data,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_flush_data,
    output logic              s_we,
    output line_st_t          s_wst
);
    logic hit, is_rd, is_rdx, is_upg;

    assign hit    = snp_valid && st_valid(s_st) && (s_tag == snp_tag);
    assign is_rd  = snp_op == BUS_RD;
    assign is_rdx = snp_op == BUS_RDX;
    assign is_upg = snp_op == BUS_UPGR;

    always_comb begin
        snp_shared     = hit && is_rd;
        snp_flush      = hit && (s_st == ST_M) && (is_rd || is_rdx);
        snp_flush_data = s_data;
        s_we           = 1'b0;
        s_wst          = s_st;
        if (hit && is_rd && st_owned(s_st)) begin
            s_we  = 1'b1;
            s_wst = ST_S;
        end else if (hit && (is_rdx || is_upg)) begin
            s_we  = 1'b1;
            s_wst = ST_I;
        end
    end

    // R7/R8: data is only ever flushed from a dirty line
    a_r8_flush_from_dirty: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> (snp_valid && s_st == ST_M));

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              snp_block,
    output logic              bus_req_valid,
    output logic [2:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rsp_data,
    input  logic              bus_rsp_shared,
    input  logic [ADDR_W-IDX_W-1:0] p_tag,
    input  line_st_t          p_st,
    input  logic [DATA_W-1:0] p_data,
    output logic              p_we,
    output logic [ADDR_W-IDX_W-1:0] p_wtag,
    output line_st_t          p_wst,
    output logic [DATA_W-1:0] p_wdata
);
    localparam int TAG_W = ADDR_W - IDX_W;

    req_fsm_t cur, nxt;
    logic [TAG_W-1:0] ctag;
    logic [IDX_W-1:0] cidx;
    logic hit;

    assign ctag      = cpu_addr[ADDR_W-1:IDX_W];
    assign cidx      = cpu_addr[IDX_W-1:0];
    assign hit       = st_valid(p_st) && (p_tag == ctag);
    assign cpu_rdata = p_data;

    always_comb begin
        nxt           = cur;
        cpu_ready     = 1'b0;
        bus_req_valid = 1'b0;
        bus_req_op    = BUS_NONE;
        bus_req_addr  = cpu_addr;
        bus_req_data  = '0;
        p_we          = 1'b0;
        p_wtag        = p_tag;
        p_wst         = p_st;
        p_wdata       = p_data;
        unique case (cur)
            F_IDLE: if (cpu_valid && !snp_block) begin
                if (hit && (!cpu_write || st_owned(p_st))) begin
                    cpu_ready = 1'b1;
                    if (cpu_write) begin
                        p_we    = 1'b1;
                        p_wst   = ST_M;
                        p_wdata = cpu_wdata;
                    end
                end else if (hit) begin
                    nxt = F_UPG;
                end else if (p_st == ST_M) begin
                    nxt = F_WB;
                end else begin
                    nxt = F_FILL;
                end
            end
            F_WB: if (p_st != ST_M) begin
                nxt = F_IDLE;              // demoted by a snoop: now clean
            end else begin
                bus_req_valid = 1'b1;
                bus_req_op    = BUS_WB;
                bus_req_addr  = {p_tag, cidx};
                bus_req_data  = p_data;
                if (bus_gnt) begin
                    p_we  = 1'b1;
                    p_wst = ST_I;
                    nxt   = F_IDLE;
                end
            end
            F_FILL: begin
                bus_req_valid = 1'b1;
                bus_req_op    = cpu_write ? BUS_RDX : BUS_RD;
                if (bus_gnt) begin
                    p_we    = 1'b1;
                    p_wtag  = ctag;
                    p_wdata = bus_rsp_data;
                    p_wst   = cpu_write ? ST_M : (bus_rsp_shared ? ST_S : ST_E);
                    nxt     = F_IDLE;
                end
            end
            F_UPG: if (!(hit && p_st == ST_S)) begin
                nxt = F_IDLE;              // lost the copy: retry as a miss
            end else begin
                bus_req_valid = 1'b1;
                bus_req_op    = BUS_UPGR;
                if (bus_gnt) begin
                    p_we  = 1'b1;
                    p_wst = ST_M;
                    nxt   = F_IDLE;
                end
            end
            default: nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= F_IDLE;
        else     cur <= nxt;
    end

    a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (cur != F_IDLE) |-> !cpu_ready);
    a_r6_hit_no_bus: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !bus_req_valid);
    a_r5_upgrade_from_shared: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_op == BUS_UPGR) |-> (p_st == ST_S));
    a_r9_wb_only_dirty: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_op == BUS_WB) |-> (p_st == ST_M));

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req_valid,
    output logic [2:0]        bus_req_op,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rsp_data,
    input  logic              bus_rsp_shared,
    input  logic              snp_valid,
    input  logic [2:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_flush_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0]  p_tag, p_wtag, s_tag;
    line_st_t          p_st, p_wst, s_st, s_wst;
    logic [DATA_W-1:0] p_data, p_wdata, s_data;
    logic              p_we, s_we, snp_block;

    assign snp_block = snp_valid && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);

    coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .p_idx(cpu_addr[IDX_W-1:0]), .p_tag(p_tag), .p_st(p_st), .p_data(p_data),
        .p_we(p_we), .p_wtag(p_wtag), .p_wst(p_wst), .p_wdata(p_wdata),
        .s_idx(snp_addr[IDX_W-1:0]), .s_tag(s_tag), .s_st(s_st), .s_data(s_data),
        .s_we(s_we), .s_wst(s_wst)
    );

    coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .s_tag(s_tag), .s_st(s_st), .s_data(s_data),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_flush_data(snp_flush_data),
        .s_we(s_we), .s_wst(s_wst)
    );

    coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .snp_block(snp_block),
        .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_gnt(bus_gnt), .bus_rsp_data(bus_rsp_data), .bus_rsp_shared(bus_rsp_shared),
        .p_tag(p_tag), .p_st(p_st), .p_data(p_data),
        .p_we(p_we), .p_wtag(p_wtag), .p_wst(p_wst), .p_wdata(p_wdata)
    );

    // R11: a snoop on the same line index always stalls the processor side
    a_r11_snoop_stalls_cpu: assert property (@(posedge clk) disable iff (rst)
        snp_block |-> !cpu_ready);
    // R12: a granted transaction is one this controller asked for
    a_r12_gnt_needs_req: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && !snp_valid) |-> (bus_req_valid || !cpu_valid || cpu_ready || !$past(cpu_valid)));

endmodule

// File: tb/sim_coh_snoop_ctrl.sv
module sim_coh_snoop_ctrl;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic bus_req_valid;
    logic [2:0] bus_req_op;
    logic [ADDR_W-1:0] bus_req_addr;
    logic [DATA_W-1:0] bus_req_data;
    logic bus_gnt = 1'b0, bus_rsp_shared = 1'b0;
    logic [DATA_W-1:0] bus_rsp_data = '0;
    logic snp_valid = 1'b0;
    logic [2:0] snp_op = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic snp_shared, snp_flush;
    logic [DATA_W-1:0] snp_flush_data;

    always #5 clk = ~clk;

    coh_snoop_ctrl u0 (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_gnt(bus_gnt), .bus_rsp_data(bus_rsp_data), .bus_rsp_shared(bus_rsp_shared),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
    );

    int n_tests = 0, n_fail = 0;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one processor request; grants every bus request, recording op codes 3 bits each
    task automatic run_cpu(input logic w, input logic [7:0] a, input logic [15:0] d,
                           input logic [15:0] fill, input logic sh,
                           output logic [11:0] seq, output logic [15:0] rd);
        bit done = 0;
        seq = '0; rd = '0;
        @(negedge clk);
        cpu_valid = 1; cpu_write = w; cpu_addr = a; cpu_wdata = d;
        for (int k = 0; k < 20 && !done; k++) begin
            #1;
            if (cpu_ready) begin
                rd = cpu_rdata; done = 1;
            end else if (bus_req_valid) begin
                seq = {seq[8:0], bus_req_op};
                if (bus_req_op == 3'd4) begin wb_addr = bus_req_addr; wb_data = bus_req_data; end
                bus_gnt = 1; bus_rsp_data = fill; bus_rsp_shared = sh;
            end
            @(posedge clk); #1;
            bus_gnt = 0;
            if (!done) @(negedge clk);
        end
        cpu_valid = 0;
        if (!done) check("R12 request completes", 0, 1);
    endtask

    task automatic snoop(input logic [2:0] op, input logic [7:0] a,
                         output logic sh, output logic fl, output logic [15:0] fd);
        @(negedge clk);
        snp_valid = 1; snp_op = op; snp_addr = a;
        #1; sh = snp_shared; fl = snp_flush; fd = snp_flush_data;
        @(posedge clk); #1;
        snp_valid = 0;
    endtask

    typedef struct packed {
        logic        w;
        logic [7:0]  addr;
        logic [15:0] wdata;
        logic [15:0] fill;
        logic        sh;
        logic [11:0] seq;
        logic [15:0] rdata;
    } vec_t;

    // op codes: 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back; line index = addr[1:0]
    localparam vec_t VEC [12] = '{
        '{1'b0, 8'h10, 16'h0,    16'hA5A5, 1'b0, 12'o1,  16'hA5A5}, // R3 miss, fill E
        '{1'b1, 8'h10, 16'h1111, 16'h0,    1'b0, 12'o0,  16'h0},    // R6 E->M silent
        '{1'b0, 8'h10, 16'h0,    16'h0,    1'b0, 12'o0,  16'h1111}, // R2 hit M
        '{1'b0, 8'h21, 16'h0,    16'h2222, 1'b1, 12'o1,  16'h2222}, // R3 miss, fill S
        '{1'b1, 8'h21, 16'h3333, 16'h0,    1'b0, 12'o3,  16'h0},    // R5 upgrade
        '{1'b0, 8'h21, 16'h0,    16'h0,    1'b0, 12'o0,  16'h3333}, // R2 hit after upgrade
        '{1'b0, 8'h14, 16'h0,    16'h4444, 1'b0, 12'o41, 16'h4444}, // R9 dirty victim
        '{1'b1, 8'h32, 16'h6666, 16'h5555, 1'b0, 12'o2,  16'h0},    // R4 write miss
        '{1'b0, 8'h32, 16'h0,    16'h0,    1'b0, 12'o0,  16'h6666}, // R4 data kept
        '{1'b0, 8'h18, 16'h0,    16'h7777, 1'b1, 12'o1,  16'h7777}, // R9 clean victim
        '{1'b1, 8'h18, 16'h8888, 16'h0,    1'b0, 12'o3,  16'h0},    // R5 upgrade
        '{1'b0, 8'h18, 16'h0,    16'h0,    1'b0, 12'o0,  16'h8888}  // R2 hit
    };

    initial begin
        #2_000_000;
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] seq;
        logic [15:0] rd, fd;
        logic sh, fl;

        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        @(negedge clk); #1;
        check("R1 no bus request after reset", bus_req_valid, 0);
        check("R1 not ready while idle", cpu_ready, 0);
        snoop(3'd1, 8'h10, sh, fl, fd);
        check("R1 snooped read of empty cache not shared", sh, 0);

        // vector table
        for (int i = 0; i < 12; i++) begin
            run_cpu(VEC[i].w, VEC[i].addr, VEC[i].wdata, VEC[i].fill, VEC[i].sh, seq, rd);
            check($sformatf("R2/R3/R4/R5/R6/R9 bus ops vec %0d", i), seq, VEC[i].seq);
            if (!VEC[i].w) check($sformatf("R2/R3 read data vec %0d", i), rd, VEC[i].rdata);
            if (i == 6) begin
                check("R9 write-back address", wb_addr, 8'h10);
                check("R9 write-back data", wb_data, 16'h1111);
            end
        end

        // R7: snooped read of a modified line: shared, flush, demote
        snoop(3'd1, 8'h18, sh, fl, fd);
        check("R7 shared on M", sh, 1);
        check("R7 flush on M", fl, 1);
        check("R7 flush data", fd, 16'h8888);
        snoop(3'd1, 8'h18, sh, fl, fd);
        check("R7 shared after demote", sh, 1);
        check("R7 no flush once shared", fl, 0);
        snoop(3'd1, 8'h3B, sh, fl, fd);
        check("R7 invalid line not shared", sh, 0);
        snoop(3'd1, 8'h28, sh, fl, fd);
        check("R7 tag mismatch not shared", sh, 0);

        // R8: read-for-ownership on M flushes and invalidates
        snoop(3'd2, 8'h21, sh, fl, fd);
        check("R8 flush on rdx", fl, 1);
        check("R8 flush data", fd, 16'h3333);
        run_cpu(0, 8'h21, 16'h0, 16'h9999, 0, seq, rd);
        check("R8 line invalid after rdx", seq, 12'o1);
        check("R8 refetched data", rd, 16'h9999);

        // R8: upgrade on S invalidates, no flush
        snoop(3'd3, 8'h18, sh, fl, fd);
        check("R8 no flush on upgrade", fl, 0);
        run_cpu(0, 8'h18, 16'h0, 16'h7A7A, 0, seq, rd);
        check("R8 line invalid after upgrade snoop", seq, 12'o1);

        // R7: E demoted to S, so a store needs an upgrade
        snoop(3'd1, 8'h18, sh, fl, fd);
        check("R7 shared on E", sh, 1);
        check("R7 no flush on E", fl, 0);
        run_cpu(1, 8'h18, 16'hBBBB, 16'h0, 0, seq, rd);
        check("R7 E demoted to S", seq, 12'o3);

        // R10: upgrade withdrawn when invalidated before grant
        snoop(3'd1, 8'h18, sh, fl, fd);
        check("R7 flush data BBBB", fd, 16'hBBBB);
        @(negedge clk);
        cpu_valid = 1; cpu_write = 1; cpu_addr = 8'h18; cpu_wdata = 16'hCCCC;
        #1 check("R12 no ready on shared store", cpu_ready, 0);
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1; snp_op = 3'd3; snp_addr = 8'h18;
        #1;
        check("R5 upgrade requested", bus_req_valid, 1);
        check("R5 upgrade op", bus_req_op, 3);
        check("R12 stalled during upgrade", cpu_ready, 0);
        @(posedge clk); #1 snp_valid = 0;
        @(negedge clk); #1;
        check("R10 upgrade withdrawn", bus_req_valid, 0);
        run_cpu(1, 8'h18, 16'hCCCC, 16'hDDDD, 0, seq, rd);
        check("R10 store retried as rdx", seq, 12'o2);
        run_cpu(0, 8'h18, 16'h0, 16'h0, 0, seq, rd);
        check("R10 stored data", rd, 16'hCCCC);

        // R11: snoop on same index stalls the processor for that cycle
        @(negedge clk);
        cpu_valid = 1; cpu_write = 0; cpu_addr = 8'h32;
        snp_valid = 1; snp_op = 3'd1; snp_addr = 8'h32;
        #1;
        check("R11 stall on snoop collision", cpu_ready, 0);
        check("R11 snoop still flushes", snp_flush, 1);
        @(posedge clk); #1 snp_valid = 0;
        @(negedge clk); #1;
        check("R11 ready after snoop", cpu_ready, 1);
        check("R11 data after snoop", cpu_rdata, 16'h6666);
        @(posedge clk); #1 cpu_valid = 0;
        run_cpu(1, 8'h32, 16'hEEEE, 16'h0, 0, seq, rd);
        check("R11 line demoted to S", seq, 12'o3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule